// File: doc/BRIEF.md
# Two-Way Set-Associative Instruction Cache

This block is a read-only first-level instruction cache placed between an instruction fetch stage and a backing instruction memory. Fetch raises a read enable with a word address while the cache is idle. The cache then checks both ways of the addressed set. On a hit it returns the stored word. On a miss it fetches the word from memory with a blocking request/ready handshake, writes it into the way that was not used most recently, and returns it.

Each set has two single-word ways and one replacement bit. The controller state is driven on a 2-bit output, so fetch can see when the cache is idle again. Once the state is idle, the returned word stays on the data output until the next request completes.

Top module: `icache_2way`

## Requirements
- R1: After the asynchronous active-low reset, state_o is 0, mem_req_o is low and rdata_o is 0. Every way of every set is invalid, so the first access to any address is a miss.
- R2: The set index is req_addr_i[IDX_W-1:0] (7 bits by default). The tag is the remaining upper ADDR_W-IDX_W bits. Addresses that differ only in the tag share one set and compete for its two ways.
- R3: The state encodings are idle = 0, lookup = 1 and refill = 2, and state_o never shows 3. read_enable is sampled only when the state is idle. When it is sampled, the address is latched and state_o reads 1 after the next clock edge.
- R4: A hit needs a valid way whose tag equals the request tag. On a hit the cache spends one cycle in lookup, then returns to idle with that way's word on rdata_o. mem_req_o is never raised during a hit.
- R5: On a miss the state goes from lookup to refill (2). mem_req_o is high and mem_addr_o carries the latched request address. Both stay steady until mem_ready_i is seen high.
- R6: On the cycle where mem_req_o and mem_ready_i are both high, mem_rdata_i is captured into rdata_o and into the victim way, and that way's tag and valid bit are set. On the next cycle the state is idle and mem_req_o is low.
- R7: The victim is chosen by the set's replacement bit: 0 picks way 0 and 1 picks way 1. After reset every replacement bit is 0.
- R8: Every hit and every fill marks the accessed way as most recent, so the set's replacement bit then points at the other way.
- R9: A read enable that arrives while the state is not idle is ignored. Its address is neither looked up nor filled, and it does not start a new access.
- R10: A refill may wait any number of cycles for mem_ready_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| read_en_i | input | 1 | Fetch read request, sampled only when idle |
| req_addr_i | input | ADDR_W | Fetch word address |
| mem_rdata_i | input | DATA_W | Word returned by instruction memory |
| mem_ready_i | input | 1 | Memory data valid for the pending request |
| rdata_o | output | DATA_W | Returned instruction word |
| mem_req_o | output | 1 | Refill request to memory |
| mem_addr_o | output | ADDR_W | Refill address |
| state_o | output | 2 | Controller state: 0 idle, 1 lookup, 2 refill |

## Verification
The assertions check the controller on every cycle:
- state_o never takes the unused code 3.
- Lookup always leaves after one cycle, and a sampled read enable always enters lookup.
- A pending refill request keeps its address steady until ready.
- A ready handshake returns the cache to idle with the memory word on rdata_o.
- No two ways hit at once.

Only the bench's scenarios can show the replacement order, the hit or miss outcome for a given history of addresses, and the words returned. The bench compares these against a reference model of sets, tags and replacement bits. The model tracks sweeps over all sets, conflicting tags, varying refill latency and read enables pulsed during a refill.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_REFILL = 2'd2
  } ic_state_e;
endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store #(
  parameter int IDX_W = 7,
  parameter int TAG_W = 25,
  parameter int WAYS  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  output logic [WAYS-1:0]  hit_o,
  input  logic             fill_en_i,
  input  logic [WAYS-1:0]  fill_way_oh_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [TAG_W-1:0] fill_tag_i
);
  localparam int SETS = 1 << IDX_W;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]  valid_q;
    logic [TAG_W-1:0] tag_q [SETS];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= '0;
        tag_q   <= '{default: '0};
      end else if (fill_en_i && fill_way_oh_i[w]) begin
        valid_q[fill_idx_i] <= 1'b1;
        tag_q[fill_idx_i]   <= fill_tag_i;
      end
    end

    assign hit_o[w] = valid_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);
  end
endmodule

// File: rtl/icache_data_store.sv
module icache_data_store #(
  parameter int IDX_W  = 7,
  parameter int DATA_W = 32,
  parameter int WAYS   = 2
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o [WAYS],
  input  logic              wr_en_i,
  input  logic [WAYS-1:0]   wr_way_oh_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  localparam int SETS = 1 << IDX_W;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [DATA_W-1:0] mem_q [SETS];

    // data needs no reset: valid bits gate its use
    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_way_oh_i[w]) mem_q[wr_idx_i] <= wr_data_i;
    end

    assign rd_data_o[w] = mem_q[rd_idx_i];
  end
endmodule

// File: rtl/icache_lru.sv
module icache_lru #(
  parameter int IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  output logic             victim_o,
  input  logic             upd_en_i,
  input  logic             upd_way_i
);
  localparam int SETS = 1 << IDX_W;

  // bit holds the way to evict next
  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lru_q        <= '0;
    else if (upd_en_i) lru_q[idx_i] <= ~upd_way_i;
  end

  assign victim_o = lru_q[idx_i];
endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              read_en_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [1:0]        hit_i,
  input  logic [DATA_W-1:0] way0_data_i,
  input  logic [DATA_W-1:0] way1_data_i,
  input  logic              victim_i,
  output ic_state_e         state_o,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              fill_en_o,
  output logic              fill_way_o,
  output logic              lru_upd_en_o,
  output logic              lru_upd_way_o,
  output logic              mem_req_o
);
  ic_state_e         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] rdata_q;
  logic              victim_q;
  logic              hit_any;

  assign hit_any = |hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      rdata_q  <= '0;
      victim_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (read_en_i) begin
          addr_q  <= req_addr_i;
          state_q <= ST_LOOKUP;
        end
        ST_LOOKUP: if (hit_any) begin
          rdata_q <= hit_i[1] ? way1_data_i : way0_data_i;
          state_q <= ST_IDLE;
        end else begin
          victim_q <= victim_i;
          state_q  <= ST_REFILL;
        end
        ST_REFILL: if (mem_ready_i) begin
          rdata_q <= mem_rdata_i;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o     = (state_q == ST_REFILL);
  assign fill_en_o     = mem_req_o && mem_ready_i;
  assign fill_way_o    = victim_q;
  assign lru_upd_en_o  = ((state_q == ST_LOOKUP) && hit_any) || fill_en_o;
  assign lru_upd_way_o = fill_en_o ? victim_q : hit_i[1];
  assign state_o       = state_q;
  assign addr_q_o      = addr_q;
  assign rdata_o       = rdata_q;

  // R3
  state_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != 2'd3);
  // R3
  idle_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && read_en_i) |=> state_q == ST_LOOKUP);
  // R4
  lookup_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_LOOKUP |=> state_q != ST_LOOKUP);
  // R5
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(addr_q)));
  // R6
  fill_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ready_i) |=> (state_q == ST_IDLE && !mem_req_o &&
                                    rdata_q == $past(mem_rdata_i)));
  // R9
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REFILL && !mem_ready_i) |=> state_q == ST_REFILL);
endmodule

// File: rtl/icache_2way.sv
module icache_2way
  import icache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              read_en_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        state_o
);
  localparam int WAYS  = 2;
  localparam int TAG_W = ADDR_W - IDX_W;

  ic_state_e         state;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [WAYS-1:0]   hit;
  logic [DATA_W-1:0] way_data [WAYS];
  logic              victim, fill_en, fill_way, lru_upd_en, lru_upd_way;
  logic [WAYS-1:0]   fill_oh;

  assign idx     = addr_q[IDX_W-1:0];
  assign tag     = addr_q[ADDR_W-1:IDX_W];
  assign fill_oh = fill_way ? 2'b10 : 2'b01;

  icache_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .WAYS(WAYS)) u_tags (
    .clk_i, .rst_ni,
    .rd_idx_i(idx), .rd_tag_i(tag), .hit_o(hit),
    .fill_en_i(fill_en), .fill_way_oh_i(fill_oh),
    .fill_idx_i(idx), .fill_tag_i(tag)
  );

  icache_data_store #(.IDX_W(IDX_W), .DATA_W(DATA_W), .WAYS(WAYS)) u_data (
    .clk_i,
    .rd_idx_i(idx), .rd_data_o(way_data),
    .wr_en_i(fill_en), .wr_way_oh_i(fill_oh),
    .wr_idx_i(idx), .wr_data_i(mem_rdata_i)
  );

  icache_lru #(.IDX_W(IDX_W)) u_lru (
    .clk_i, .rst_ni,
    .idx_i(idx), .victim_o(victim),
    .upd_en_i(lru_upd_en), .upd_way_i(lru_upd_way)
  );

  icache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni,
    .read_en_i, .req_addr_i, .mem_ready_i, .mem_rdata_i,
    .hit_i(hit), .way0_data_i(way_data[0]), .way1_data_i(way_data[1]),
    .victim_i(victim),
    .state_o(state), .addr_q_o(addr_q), .rdata_o(rdata_o),
    .fill_en_o(fill_en), .fill_way_o(fill_way),
    .lru_upd_en_o(lru_upd_en), .lru_upd_way_o(lru_upd_way),
    .mem_req_o(mem_req_o)
  );

  assign mem_addr_o = addr_q;
  assign state_o    = state;

  // R4
  single_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_LOOKUP |-> $onehot0(hit));
  // R4
  hit_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_LOOKUP && |hit) |=> !mem_req_o);
endmodule

// File: tb/icache_2way_tb.sv
module icache_2way_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 7;
  localparam int SETS  = 1 << IDX_W;

  logic        clk = 0, rst_n = 0;
  logic        read_en = 0, mem_ready = 0;
  logic [31:0] req_addr = '0, mem_rdata = '0;
  logic [31:0] rdata, mem_addr;
  logic        mem_req;
  logic [1:0]  state;

  int n_chk = 0, n_bad = 0;

  // reference model
  bit          m_valid [2][SETS];
  logic [24:0] m_tag   [2][SETS];
  logic [31:0] m_data  [2][SETS];
  bit          m_lru   [SETS];

  always #(CLK_PERIOD/2) clk = ~clk;

  icache_2way dut_i (
    .clk_i(clk), .rst_ni(rst_n), .read_en_i(read_en), .req_addr_i(req_addr),
    .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready),
    .rdata_o(rdata), .mem_req_o(mem_req), .mem_addr_o(mem_addr), .state_o(state)
  );

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h13579BDF;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic access(logic [31:0] a, int lat, bit poke, logic [31:0] poke_a);
    int idx = int'(a[IDX_W-1:0]);
    logic [24:0] tg = a[31:IDX_W];
    bit exp_hit = 0, saw_req = 0, addr_bad = 0;
    int hw = 0, waited = 0, cyc = 0;
    logic [31:0] exp_d;
    for (int w = 0; w < 2; w++)
      if (m_valid[w][idx] && m_tag[w][idx] == tg) begin exp_hit = 1; hw = w; end
    @(negedge clk); read_en = 1; req_addr = a;
    @(negedge clk); read_en = 0;
    chk(state == 2'd1, "R3", {30'd0, state}, 32'd1);
    while (state != 2'd0 && cyc < 60) begin
      read_en = 0; mem_ready = 0;
      if (mem_req) begin
        saw_req = 1;
        if (mem_addr != a) addr_bad = 1;
        if (poke && waited == 0) begin read_en = 1; req_addr = poke_a; end
        if (waited >= lat) begin mem_ready = 1; mem_rdata = mem_word(a); end
        waited++;
      end
      @(negedge clk); cyc++;
    end
    read_en = 0; mem_ready = 0; mem_rdata = 32'hDEAD_BEEF;
    chk(cyc < 60, "R10", cyc, 60);
    if (exp_hit) begin
      exp_d = m_data[hw][idx];
      m_lru[idx] = (hw == 0);
      chk(!saw_req, "R4", saw_req, 0);
    end else begin
      int v = int'(m_lru[idx]);
      exp_d = mem_word(a);
      m_valid[v][idx] = 1; m_tag[v][idx] = tg; m_data[v][idx] = exp_d;
      m_lru[idx] = (v == 0);
      chk(saw_req, "R5", saw_req, 1);
      chk(!addr_bad, "R5", addr_bad, 0);
    end
    chk(rdata == exp_d, exp_hit ? "R4" : "R6", rdata, exp_d);
    chk(!mem_req, "R6", mem_req, 0);
    if (poke) begin
      @(negedge clk);
      chk(state == 2'd0, "R9", {30'd0, state}, 0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < SETS; s++) begin
      m_lru[s] = 0;
      for (int w = 0; w < 2; w++) begin m_valid[w][s] = 0; m_tag[w][s] = '0; m_data[w][s] = '0; end
    end
    repeat (3) @(negedge clk);
    // R1
    chk(state == 2'd0 && !mem_req && rdata == 0, "R1", rdata, 0);
    rst_n = 1;
    @(negedge clk);
    chk(state == 2'd0 && !mem_req, "R1", {30'd0, state}, 0);
    // R1 R7: cold misses fill way 0 across all sets
    for (int s = 0; s < SETS; s++) access(32'(s), s % 4, 0, 0);
    // R4: all hit
    for (int s = 0; s < SETS; s++) access(32'(s), 0, 0, 0);
    // R2 R7: conflicting tag fills way 1
    for (int s = 0; s < SETS; s++) access(32'(s) | (32'd1 << IDX_W), (s % 3) + 1, 0, 0);
    // both ways now hit
    for (int s = 0; s < SETS; s++) begin
      access(32'(s), 0, 0, 0);
      access(32'(s) | (32'd1 << IDX_W), 0, 0, 0);
    end
    // R8: third tag evicts least recent, then recheck older tags
    for (int s = 0; s < 32; s++) begin
      access(32'(s) | (32'd2 << IDX_W), s % 5, 0, 0);
      access(32'(s) | (32'd1 << IDX_W), 1, 0, 0);
      access(32'(s), 2, 0, 0);
      access(32'(s) | (32'd2 << IDX_W), 0, 0, 0);
    end
    // R10: long refill; R9: read enable during refill is ignored
    access(32'h00ABC000 | 32'd9, 40, 1, 32'h00F00000 | 32'd77);
    access(32'h00F00000 | 32'd77, 3, 0, 0);
    access(32'h12345000 | 32'd100, 7, 1, 32'h00ABC000 | 32'd9);
    access(32'h00ABC000 | 32'd9, 0, 0, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule